// File: doc/BRIEF.md
# Prescaled Output-Compare Timer

This block keeps a 16-bit free-running up-counter that advances once per tick of a programmable prescaler. Five compare units watch the counter. Four of them each own one output pin. The fifth, the master unit, can drive any group of those pins at once through a mask and a data pattern. When the counter advances onto a unit's compare value, the unit's flag is set and its pin action is applied. An interrupt line is raised for any flag whose enable bit is set.

Software reaches every register through a byte-wide bus with write and read strobes and combinational read data. The prescaler choice is fixed early in life: it is accepted only inside a short window after reset. Flags are cleared by writing 1 to them. A force strobe applies a unit's pin action without touching the flags. Reading the counter's high byte captures the low byte, so two byte reads always form one coherent 16-bit value.

Top module: `prescaled_oc_timer`

## Requirements
- R1: After synchronous reset the counter reads 0x0000 and the flag byte (address 0x03) reads 0x00. The pins and irq are low, the prescaler select (address 0x02, bits 1:0) reads 00, and every compare register reads 0xFFFF. Compare unit k (k = 0..3 single-pin, k = 4 master) has its high byte at address 0x10+2k and its low byte at 0x11+2k.
- R2: A select code of 00, 01, 10 or 11 makes the counter advance once every 1, 4, 8 or 16 clocks respectively.
- R3: The select bits accept writes only during the first 64 clocks after reset. A write in clock 63 takes effect. A write in clock 64 or later is ignored.
- R4: The counter cannot be written, since writes to addresses 0x00 and 0x01 have no effect. It adds one per prescaler tick and wraps from 0xFFFF to 0x0000. On that wrap it sets the overflow flag, bit 7 of address 0x03, in the cycle the counter first shows 0x0000.
- R5: When the counter advances onto the compare value of unit k, flag bit k of address 0x03 is set. It becomes visible in the same cycle that the counter first shows that value.
- R6: Address 0x05 holds a 2-bit action for each single-pin unit k in bits [2k+1:2k]. On a match, pin k does the following: 00 leaves it alone, 01 toggles it, 10 drives it low, 11 drives it high.
- R7: irq is high exactly while some flag bit is set whose enable bit is also set. The enable bits are at address 0x04, in the same bit positions as the flags.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A set in the same cycle as a clear wins over the clear.
- R9: Writing 1 to bit k of address 0x06 applies unit k's pin action on that edge (bit 4 selects the master). The force sets no flag and leaves the compare value unchanged. A pin toggled by a force toggles again at the next real match.
- R10: On a match or force of the master unit, every pin i with bit i set in the mask (address 0x07) takes bit i of the data register (address 0x08). When a single-pin unit acts on the same pin in the same edge, the master's data wins.
- R11: Reading address 0x00 returns the counter's high byte and captures its low byte at that moment. A following read of address 0x01 returns the captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| oc_pin | output | 4 | Compare output pins |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase or counter value is exposed at the next counter read. The bench predicts the absolute count from the number of clocks since reset, so even a one-clock slip is seen at once. A compare that fires a cycle early or late shows up on the pins and the flag byte at the single cycle where the counter reaches the target. That is why each match is sampled in both the cycle before it and the cycle of it. A flag or pin register that is corrupted by a force, a write of 0, or a blocked late prescaler write remains visible on the ports until the next read of that register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W      = 16;
    localparam int BYTE_W     = 8;
    localparam int NUM_CH     = 4;
    localparam int NUM_CMP    = NUM_CH + 1;
    localparam int MASTER     = NUM_CH;
    localparam int ADDR_W     = 5;
    localparam int PRE_W      = 4;
    localparam int SEL_W      = 2;
    localparam int INIT_WINDOW = 64;
    localparam int OVF_BIT    = 7;
    localparam int CMP_BASE   = 16;

    localparam logic [ADDR_W-1:0] A_CNT_HI = 5'h00;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 5'h01;
    localparam logic [ADDR_W-1:0] A_PSEL   = 5'h02;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 5'h03;
    localparam logic [ADDR_W-1:0] A_IEN    = 5'h04;
    localparam logic [ADDR_W-1:0] A_ACTION = 5'h05;
    localparam logic [ADDR_W-1:0] A_FORCE  = 5'h06;
    localparam logic [ADDR_W-1:0] A_MMASK  = 5'h07;
    localparam logic [ADDR_W-1:0] A_MDATA  = 5'h08;

    localparam logic [BYTE_W-1:0] FLAG_USED =
        BYTE_W'((1 << OVF_BIT) | ((1 << NUM_CMP) - 1));

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_e;

    typedef struct packed {
        logic hit;
        logic forced;
    } oc_evt_t;

    function automatic logic [PRE_W-1:0] div_last(input logic [SEL_W-1:0] sel);
        case (sel)
            2'b00:   div_last = 4'd0;
            2'b01:   div_last = 4'd3;
            2'b10:   div_last = 4'd7;
            default: div_last = 4'd15;
        endcase
    endfunction

    function automatic logic pin_apply(input act_e act, input logic cur);
        case (act)
            ACT_TOGGLE: pin_apply = ~cur;
            ACT_LOW:    pin_apply = 1'b0;
            ACT_HIGH:   pin_apply = 1'b1;
            default:    pin_apply = cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int WINDOW = INIT_WINDOW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    output logic [SEL_W-1:0] sel_q,
    output logic             tick
);
    localparam int WIN_W = $clog2(WINDOW + 1);

    logic [WIN_W-1:0] win_cnt;
    logic             win_open;
    logic [PRE_W-1:0] pre_cnt;

    assign win_open = win_cnt < WIN_W'(WINDOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt <= '0;
        end else if (win_open) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (sel_we && win_open) begin
            sel_q <= sel_wdata;
        end
    end

    assign tick = pre_cnt >= div_last(sel_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R3: once the window has closed the select code is frozen
    p_sel_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        !win_open |=> $stable(sel_q));

    // R2: with any divider above one, ticks never come back to back
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && sel_q != 2'b00 && !sel_we) |=> !tick);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = tick && (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the count moves by exactly one per tick and holds otherwise
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == CNT_W'($past(cnt) + 1'b1));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));

    // R4: a wrap lands on zero
    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt == '0);

endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_hi,
    input  logic              we_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              tick,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              match
);
    logic [CNT_W-1:0] cnt_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
        end else begin
            if (we_hi) begin
                cmp_q[CNT_W-1:BYTE_W] <= wdata;
            end
            if (we_lo) begin
                cmp_q[BYTE_W-1:0] <= wdata;
            end
        end
    end

    // a match is the edge on which the counter steps onto the value
    assign cnt_nxt = cnt + 1'b1;
    assign match   = tick && (cnt_nxt == cmp_q);

    // R9: only a bus write moves a compare value
    p_cmp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(we_hi || we_lo) |=> $stable(cmp_q));

endmodule

// File: rtl/prescaled_oc_timer.sv
module prescaled_oc_timer
    import tmr_pkg::*;
#(
    parameter int WINDOW = INIT_WINDOW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] oc_pin,
    output logic              irq
);
    logic                tick;
    logic                wrap;
    logic [SEL_W-1:0]    sel_q;
    logic [CNT_W-1:0]    cnt;
    logic [BYTE_W-1:0]   lo_hold;
    logic [BYTE_W-1:0]   flag_q;
    logic [BYTE_W-1:0]   ien_q;
    logic [BYTE_W-1:0]   flag_set;
    logic [BYTE_W-1:0]   flag_clr;
    logic [2*NUM_CH-1:0] act_q;
    logic [NUM_CH-1:0]   mmask_q;
    logic [NUM_CH-1:0]   mdata_q;
    logic [NUM_CH-1:0]   pin_nxt;
    logic [NUM_CMP-1:0]  match;
    logic [NUM_CMP-1:0]  frc;
    logic [CNT_W-1:0]    cmp_val [NUM_CMP];
    oc_evt_t             ev      [NUM_CMP];

    logic wr_flags;
    assign wr_flags = bus_wr && (bus_addr == A_FLAGS);

    tmr_prescale #(.WINDOW(WINDOW)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .sel_we    (bus_wr && (bus_addr == A_PSEL)),
        .sel_wdata (bus_wdata[SEL_W-1:0]),
        .sel_q     (sel_q),
        .tick      (tick)
    );

    tmr_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .cnt  (cnt),
        .wrap (wrap)
    );

    for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(CMP_BASE + 2 * k);
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(CMP_BASE + 2 * k + 1);

        tmr_cmp_unit u_unit (
            .clk   (clk),
            .rst   (rst),
            .we_hi (bus_wr && (bus_addr == HI_A)),
            .we_lo (bus_wr && (bus_addr == LO_A)),
            .wdata (bus_wdata),
            .cnt   (cnt),
            .tick  (tick),
            .cmp_q (cmp_val[k]),
            .match (match[k])
        );

        assign ev[k].hit    = match[k];
        assign ev[k].forced = frc[k];

        // R5: a match always leaves its flag set
        p_match_flag_r5: assert property (@(posedge clk) disable iff (rst)
            match[k] |=> flag_q[k]);

        // R9: a force alone never raises a flag
        p_force_noflag_r9: assert property (@(posedge clk) disable iff (rst)
            (frc[k] && !match[k] && !flag_q[k]) |=> !flag_q[k]);
    end

    assign frc = (bus_wr && bus_addr == A_FORCE) ? bus_wdata[NUM_CMP-1:0] : '0;

    // counter high-byte read captures the low byte
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_hold <= '0;
        end else if (bus_rd && bus_addr == A_CNT_HI) begin
            lo_hold <= cnt[BYTE_W-1:0];
        end
    end

    // control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q   <= '0;
            act_q   <= '0;
            mmask_q <= '0;
            mdata_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_IEN:    ien_q   <= bus_wdata & FLAG_USED;
                A_ACTION: act_q   <= bus_wdata[2*NUM_CH-1:0];
                A_MMASK:  mmask_q <= bus_wdata[NUM_CH-1:0];
                A_MDATA:  mdata_q <= bus_wdata[NUM_CH-1:0];
                default:  ;
            endcase
        end
    end

    // flags: write-one-to-clear, a fresh set wins
    always_comb begin
        flag_set                = '0;
        flag_set[NUM_CMP-1:0]   = match;
        flag_set[OVF_BIT]       = wrap;
        flag_clr                = wr_flags ? bus_wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            flag_q <= ((flag_q & ~flag_clr) | flag_set) & FLAG_USED;
        end
    end

    assign irq = |(flag_q & ien_q);

    // pin actions, master data over single-pin units
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            pin_nxt[i] = oc_pin[i];
            if ((ev[MASTER].hit || ev[MASTER].forced) && mmask_q[i]) begin
                pin_nxt[i] = mdata_q[i];
            end else if (ev[i].hit || ev[i].forced) begin
                pin_nxt[i] = pin_apply(act_e'(act_q[2*i +: 2]), oc_pin[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_pin <= '0;
        end else begin
            oc_pin <= pin_nxt;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CNT_HI: bus_rdata = cnt[CNT_W-1:BYTE_W];
            A_CNT_LO: bus_rdata = lo_hold;
            A_PSEL:   bus_rdata = BYTE_W'(sel_q);
            A_FLAGS:  bus_rdata = flag_q;
            A_IEN:    bus_rdata = ien_q;
            A_ACTION: bus_rdata = BYTE_W'(act_q);
            A_MMASK:  bus_rdata = BYTE_W'(mmask_q);
            A_MDATA:  bus_rdata = BYTE_W'(mdata_q);
            default: begin
                for (int k = 0; k < NUM_CMP; k++) begin
                    if (bus_addr == ADDR_W'(CMP_BASE + 2 * k)) begin
                        bus_rdata = cmp_val[k][CNT_W-1:BYTE_W];
                    end
                    if (bus_addr == ADDR_W'(CMP_BASE + 2 * k + 1)) begin
                        bus_rdata = cmp_val[k][BYTE_W-1:0];
                    end
                end
            end
        endcase
    end

    // R4: a wrap always leaves the overflow flag set
    p_ovf_flag_r4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag_q[OVF_BIT]);

    // R11: the captured byte is the low byte seen at the high-byte read
    p_lo_latch_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_CNT_HI) |=> lo_hold == $past(cnt[BYTE_W-1:0]));

    for (genvar b = 0; b < NUM_CMP; b++) begin : g_w1c
        // R8: a clear with no competing set empties the flag
        p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
            (wr_flags && bus_wdata[b] && !match[b]) |=> !flag_q[b]);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_pri
        // R10: the master's data lands on every masked pin it touches
        p_master_pri_r10: assert property (@(posedge clk) disable iff (rst)
            ((ev[MASTER].hit || ev[MASTER].forced) && mmask_q[i])
                |=> oc_pin[i] == $past(mdata_q[i]));
    end

endmodule

// File: tb/prescaled_oc_timer_test.sv
module prescaled_oc_timer_test;
    import tmr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_DLY = CLK_PERIOD / 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [3:0]        oc_pin;
    logic              irq;

    int checks = 0;
    int errors = 0;
    int ncyc   = 0;
    bit done   = 1'b0;

    // scoreboard queues: kind 0 = read data, 1 = pins, 2 = irq
    int         kind_q[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];

    prescaled_oc_timer uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .oc_pin    (oc_pin),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) ncyc <= 0;
        else     ncyc <= ncyc + 1;
    end

    task automatic check(input bit ok, input string tag,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops every expectation pushed at this negedge
    always @(negedge clk) begin
        int         k;
        logic [7:0] e;
        logic [7:0] a;
        string      t;
        #(SAMPLE_DLY);
        while (kind_q.size() > 0) begin
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (k == 0)      a = bus_rdata;
            else if (k == 1) a = {4'b0, oc_pin};
            else             a = {7'b0, irq};
            check(a == e, t, a, e);
        end
    end

    task automatic push(input int k, input logic [7:0] e, input string t);
        kind_q.push_back(k);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // every bus task starts at a negedge and returns at the next one
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1 bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input logic [7:0] e,
                          input string t);
        bus_rd = 1'b1; bus_addr = a;
        push(0, e, t);
        @(posedge clk); #1 bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_raw(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #(SAMPLE_DLY) v = bus_rdata;
        @(posedge clk); #1 bus_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_cnt_raw(output logic [15:0] v);
        logic [7:0] hi;
        logic [7:0] lo;
        rd_raw(A_CNT_HI, hi);
        rd_raw(A_CNT_LO, lo);
        v = {hi, lo};
    endtask

    // at div 1 the count equals the clocks since reset
    task automatic rd_cnt_chk(input string t);
        logic [15:0] v;
        v = ncyc[15:0];
        rd_chk(A_CNT_HI, v[15:8], t);
        rd_chk(A_CNT_LO, v[7:0], t);
    endtask

    task automatic goto_cyc(input int n);
        while (ncyc < n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic rate_chk(input int div, input string t);
        logic [15:0] v1;
        logic [15:0] v2;
        rd_cnt_raw(v1);
        repeat (8 * div - 2) @(negedge clk);
        rd_cnt_raw(v2);
        check(16'(v2 - v1) == 16'd8, t, 16'(v2 - v1), 8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);

        // ---- divider rates and the write window (R2, R3)
        do_reset();
        wr(A_PSEL, 8'h01);
        rd_chk(A_PSEL, 8'h01, "R3 in-window write");
        rate_chk(4, "R2 div4");
        goto_cyc(63);
        wr(A_PSEL, 8'h02);
        rd_chk(A_PSEL, 8'h02, "R3 write at clock 63");

        do_reset();
        wr(A_PSEL, 8'h02);
        goto_cyc(64);
        wr(A_PSEL, 8'h00);
        rd_chk(A_PSEL, 8'h02, "R3 write at clock 64 ignored");
        rate_chk(8, "R2 div8");

        do_reset();
        wr(A_PSEL, 8'h03);
        rd_chk(A_PSEL, 8'h03, "R3 in-window write");
        rate_chk(16, "R2 div16");
        goto_cyc(200);
        wr(A_PSEL, 8'h00);
        rd_chk(A_PSEL, 8'h03, "R3 late write ignored");
        rate_chk(16, "R3 rate kept after late write");

        // ---- main run at divide by one
        do_reset();
        push(1, 8'h00, "R1 pins");
        push(2, 8'h00, "R1 irq");
        rd_chk(A_FLAGS, 8'h00, "R1 flags");
        rd_chk(A_PSEL, 8'h00, "R1 select");
        rd_chk(A_CMP_HI(0), 8'hFF, "R1 compare");
        rd_chk(A_CMP_LO(4), 8'hFF, "R1 master compare");
        rd_cnt_chk("R11 coherent read");
        rd_cnt_chk("R11 coherent read again");
        wr(A_CNT_HI, 8'h00);
        wr(A_CNT_LO, 8'h00);
        rd_cnt_chk("R4 counter not writable");
        goto_cyc(70);
        wr(A_PSEL, 8'h03);
        rd_chk(A_PSEL, 8'h00, "R3 late write ignored");
        rd_cnt_chk("R3 rate unchanged");

        // force drive-high on unit 1 (R9)
        wr(A_ACTION, 8'h0C);
        wr(A_FORCE, 8'h02);
        push(1, 8'h02, "R9 force drives pin");
        rd_chk(A_FLAGS, 8'h00, "R9 force sets no flag");

        // unit0 toggle, unit1 low, unit2 high, unit3 none, all at 300
        wr(A_ACTION, 8'h39);
        for (int k = 0; k < 4; k++) begin
            wr(A_CMP_HI(k), 8'h01);
            wr(A_CMP_LO(k), 8'h2C);
        end
        goto_cyc(299);
        push(1, 8'h02, "R5 no action before match");
        rd_chk(A_FLAGS, 8'h00, "R5 no flag before match");
        push(1, 8'h05, "R6 toggle/low/high/none");
        push(2, 8'h00, "R7 irq masked");
        rd_chk(A_FLAGS, 8'h0F, "R5 flags on match");

        // write-one-to-clear (R8)
        wr(A_FLAGS, 8'h00);
        rd_chk(A_FLAGS, 8'h0F, "R8 zero write keeps flags");
        wr(A_FLAGS, 8'h05);
        rd_chk(A_FLAGS, 8'h0A, "R8 clear by one");

        // interrupt (R7)
        wr(A_IEN, 8'h02);
        push(2, 8'h01, "R7 irq on enabled flag");
        wr(A_FLAGS, 8'h02);
        push(2, 8'h00, "R7 irq drops after clear");
        wr(A_IEN, 8'h01);
        push(2, 8'h00, "R7 enable without flag");

        // force toggle then real match toggles again (R9)
        wr(A_FORCE, 8'h01);
        push(1, 8'h04, "R9 forced toggle");
        rd_chk(A_FLAGS, 8'h08, "R9 force sets no flag");
        rd_chk(A_CMP_LO(0), 8'h2C, "R9 compare untouched");
        wr(A_CMP_HI(0), 8'h01);
        wr(A_CMP_LO(0), 8'h90);
        goto_cyc(399);
        push(1, 8'h04, "R9 before match");
        @(negedge clk);
        push(1, 8'h05, "R9 toggle at match");
        push(2, 8'h01, "R7 irq on match");
        rd_chk(A_FLAGS, 8'h09, "R5 flag at 400");
        wr(A_FLAGS, 8'hFF);
        push(2, 8'h00, "R7 irq after clear all");

        // master unit over unit 0 at 500 (R10)
        wr(A_ACTION, 8'h3B);
        wr(A_MMASK, 8'h03);
        wr(A_MDATA, 8'h02);
        wr(A_CMP_HI(0), 8'h01);
        wr(A_CMP_LO(0), 8'hF4);
        wr(A_CMP_HI(4), 8'h01);
        wr(A_CMP_LO(4), 8'hF4);
        goto_cyc(499);
        push(1, 8'h05, "R10 before master match");
        @(negedge clk);
        push(1, 8'h06, "R10 master data wins");
        rd_chk(A_FLAGS, 8'h11, "R10 master flag");
        wr(A_MDATA, 8'h01);
        wr(A_FORCE, 8'h10);
        push(1, 8'h05, "R10 master force");
        rd_chk(A_FLAGS, 8'h11, "R9 master force sets no flag");

        // overflow (R4)
        wr(A_FLAGS, 8'hFF);
        wr(A_IEN, 8'h80);
        goto_cyc(65535);
        rd_chk(A_FLAGS, 8'h00, "R4 no overflow before wrap");
        push(2, 8'h01, "R4 overflow irq");
        rd_chk(A_FLAGS, 8'h80, "R4 overflow flag");
        rd_cnt_chk("R4 wrapped count");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [ADDR_W-1:0] A_CMP_HI(input int k);
        return ADDR_W'(CMP_BASE + 2 * k);
    endfunction

    function automatic logic [ADDR_W-1:0] A_CMP_LO(input int k);
        return ADDR_W'(CMP_BASE + 2 * k + 1);
    endfunction

endmodule